// File: doc/BRIEF.md
# Radix-1000 Multi-Digit Adder

This block adds two unsigned operands. Each operand is held as `N_DIGITS` radix-1000 digits, and each digit is a 10-bit binary field with a value from 0 to 999. Digit `i` sits in bits `[10*i+9 : 10*i]` of the packed operand. For every position the block forms the 11-bit binary total `k` of the two digits and the carry arriving from the position below. Carries move upward from digit 0.

The block does not compare `k` against 1000. It adds the constant 24 and looks at bit 10 of that 11-bit result. If the bit is set, `k` has reached 1000. In that case the low ten bits of the offset total are already `k - 1000`, so they become the output digit and the position sends a carry upward. If the bit is clear, the digit is `k` and no carry leaves the position.

The whole carry chain settles within one clock period. The packed sum and the final carry are captured in an output register, so results appear one cycle after the operands are presented. The block is meant for decimal datapaths that keep groups of three decimal digits in binary form, for example iterative reciprocal units.

Top module: `r1k_adder`

## Requirements
- R1: While `rst_n` is low, `sum_out` and `carry_out` read 0, whatever the operands are.
- R2: For valid operands, output digit `i` (bits `[10*i+9:10*i]` of `sum_out`) equals `(a_i + b_i + c_i) mod 1000`. Here `c_0` is `carry_in` and `c_i` for `i > 0` is the carry produced by digit `i-1`.
- R3: A position whose total `k` is at most 999 outputs `k` unchanged and produces no carry. For example, 0+0+0 gives 0, and 600+399+0 gives 999 with no carry.
- R4: A position whose total `k` is 1000 or more outputs `k - 1000` and produces a carry of 1. For example, 600+400+0 gives 0 with a carry, and 999+999+1 gives 999 with a carry.
- R5: `carry_in` feeds digit 0, and every digit's carry feeds the next digit up within the same cycle. When every position has `a_i + b_i = 999`, `carry_in` reaches `carry_out` unchanged.
- R6: `carry_out` is the carry produced by the top digit `N_DIGITS-1`.
- R7: `sum_out` and `carry_out` are registered. They show the result for the operands sampled at the previous rising clock edge, and they hold steady while the operands do not change.
- R8: When every operand digit is 999 or less, every output digit is 999 or less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 10*N_DIGITS | First operand, packed radix-1000 digits, digit 0 lowest |
| op_b | input | 10*N_DIGITS | Second operand, same packing |
| carry_in | input | 1 | Carry into digit 0 |
| sum_out | output | 10*N_DIGITS | Registered packed sum digits |
| carry_out | output | 1 | Registered carry out of the top digit |

## Verification
Random operands are drawn with digits that lean toward 0 and 999. This lets the bench check modulo-1000 wrapping, and whether a single overflowing digit is told apart from a non-overflowing one, against an integer model that uses a plain comparison.

Directed cases each cover one corner:
- 0+0+0, 600+399 and 600+400 sit on either side of the 1000 threshold. The +24 test must agree with the comparison exactly at that threshold.
- Operands whose digit pairs all sum to 999, run with and without an incoming carry, show whether the carry really ripples through every position to `carry_out`.
- An overflow placed only in the top digit separates `carry_out` from the lower carries.
- Changing the operands just before an edge, and holding them over several edges, confirms the one-cycle latency.

// File: rtl/r1k_pkg.sv
package r1k_pkg;

    // Width of one radix-1000 digit field and of the widened digit total.
    localparam int unsigned DIGIT_W   = 10;
    localparam int unsigned TOTAL_W   = DIGIT_W + 1;

    // Largest legal digit value and the radix it implies.
    localparam int unsigned DIGIT_MAX = 999;
    localparam int unsigned RADIX     = DIGIT_MAX + 1;

    // Offset that lifts the radix up to the next power of two, so that
    // bit DIGIT_W of (total + offset) flags "total >= RADIX".
    localparam int unsigned OVF_OFFSET = (1 << DIGIT_W) - RADIX;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [TOTAL_W-1:0] total_t;

endpackage

// File: rtl/r1k_digit_cell.sv
module r1k_digit_cell
    import r1k_pkg::*;
(
    input  digit_t dig_a,
    input  digit_t dig_b,
    input  logic   c_in,
    output digit_t dig_sum,
    output logic   c_out
);

    total_t raw_total;
    total_t lifted_total;

    always_comb begin
        // Binary total of both digits and the incoming carry, at most 1999.
        raw_total    = total_t'(dig_a) + total_t'(dig_b) + total_t'(c_in);
        // Adding the offset pushes any total of RADIX or more past bit DIGIT_W.
        lifted_total = raw_total + total_t'(OVF_OFFSET);
        c_out        = lifted_total[DIGIT_W];
        // On overflow the low bits of the lifted total equal raw_total - RADIX.
        dig_sum      = c_out ? lifted_total[DIGIT_W-1:0] : raw_total[DIGIT_W-1:0];
    end

endmodule

// File: rtl/r1k_carry_chain.sv
module r1k_carry_chain
    import r1k_pkg::*;
#(
    parameter int unsigned N_DIGITS = 4
) (
    input  logic [N_DIGITS*DIGIT_W-1:0] vec_a,
    input  logic [N_DIGITS*DIGIT_W-1:0] vec_b,
    input  logic                        c_first,
    output logic [N_DIGITS*DIGIT_W-1:0] vec_sum,
    output logic [N_DIGITS-1:0]         c_each
);

    // link[i] is the carry entering digit i; link[N_DIGITS] leaves the top.
    logic [N_DIGITS:0] link;

    assign link[0] = c_first;

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_pos
        r1k_digit_cell i_cell (
            .dig_a   (vec_a[g*DIGIT_W +: DIGIT_W]),
            .dig_b   (vec_b[g*DIGIT_W +: DIGIT_W]),
            .c_in    (link[g]),
            .dig_sum (vec_sum[g*DIGIT_W +: DIGIT_W]),
            .c_out   (link[g+1])
        );
    end

    assign c_each = link[N_DIGITS:1];

endmodule

// File: rtl/r1k_adder.sv
module r1k_adder
    import r1k_pkg::*;
#(
    parameter int unsigned N_DIGITS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_DIGITS*DIGIT_W-1:0] op_a,
    input  logic [N_DIGITS*DIGIT_W-1:0] op_b,
    input  logic                        carry_in,
    output logic [N_DIGITS*DIGIT_W-1:0] sum_out,
    output logic                        carry_out
);

    localparam int unsigned SUM_W = N_DIGITS * DIGIT_W;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic             cout;
    } result_t;

    logic [SUM_W-1:0]    chain_sum;
    logic [N_DIGITS-1:0] chain_carry;

    result_t res_d;
    result_t res_q;

    r1k_carry_chain #(
        .N_DIGITS (N_DIGITS)
    ) i_chain (
        .vec_a   (op_a),
        .vec_b   (op_b),
        .c_first (carry_in),
        .vec_sum (chain_sum),
        .c_each  (chain_carry)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = chain_sum;
        res_d.cout = chain_carry[N_DIGITS-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign sum_out   = res_q.sum;
    assign carry_out = res_q.cout;

endmodule

// File: rtl/r1k_adder_chk.sv
module r1k_adder_chk
    import r1k_pkg::*;
#(
    parameter int unsigned N_DIGITS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_DIGITS*DIGIT_W-1:0] op_a,
    input logic [N_DIGITS*DIGIT_W-1:0] op_b,
    input logic                        carry_in,
    input logic [N_DIGITS*DIGIT_W-1:0] sum_out,
    input logic                        carry_out,
    input logic [N_DIGITS-1:0]         digit_carry
);

    logic [N_DIGITS:0] cin_v;
    logic              in_ok;
    logic              out_ok;
    logic              all_nines;
    logic              all_low;

    assign cin_v = {digit_carry, carry_in};

    always_comb begin
        in_ok     = 1'b1;
        out_ok    = 1'b1;
        all_nines = 1'b1;
        all_low   = 1'b1;
        for (int i = 0; i < int'(N_DIGITS); i++) begin
            if (op_a[i*DIGIT_W +: DIGIT_W] > digit_t'(DIGIT_MAX)) in_ok = 1'b0;
            if (op_b[i*DIGIT_W +: DIGIT_W] > digit_t'(DIGIT_MAX)) in_ok = 1'b0;
            if (sum_out[i*DIGIT_W +: DIGIT_W] > digit_t'(DIGIT_MAX)) out_ok = 1'b0;
            if (total_t'(op_a[i*DIGIT_W +: DIGIT_W]) + total_t'(op_b[i*DIGIT_W +: DIGIT_W])
                != total_t'(DIGIT_MAX)) all_nines = 1'b0;
            if (total_t'(op_a[i*DIGIT_W +: DIGIT_W]) + total_t'(op_b[i*DIGIT_W +: DIGIT_W])
                >= total_t'(DIGIT_MAX)) all_low = 1'b0;
        end
    end

    // R4 / R3: each position's carry agrees with a plain comparison against RADIX.
    for (genvar g = 0; g < N_DIGITS; g++) begin : g_pos
        total_t k_ref;
        assign k_ref = total_t'(op_a[g*DIGIT_W +: DIGIT_W])
                     + total_t'(op_b[g*DIGIT_W +: DIGIT_W])
                     + total_t'(cin_v[g]);

        a_r4_digit_carry: assert property (@(posedge clk) disable iff (!rst_n)
            in_ok |-> (digit_carry[g] == (k_ref >= total_t'(RADIX))));
    end

    // R8: valid operands always yield in-range output digits.
    a_r8_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_ok |=> out_ok);

    // R3: if no pair can reach 999, no carry can leave the top digit.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ok && all_low) |=> !carry_out);

    // R5: a full string of 999-sum pairs passes carry_in straight through.
    a_r5_carry_ripple: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ok && all_nines) |=> (carry_out == $past(carry_in)));

    // R7: unchanged operands keep the registered result unchanged.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(op_a) && $stable(op_b) && $stable(carry_in))
        |=> ($stable(sum_out) && $stable(carry_out)));

endmodule

bind r1k_adder r1k_adder_chk #(
    .N_DIGITS (N_DIGITS)
) i_r1k_adder_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_a        (op_a),
    .op_b        (op_b),
    .carry_in    (carry_in),
    .sum_out     (sum_out),
    .carry_out   (carry_out),
    .digit_carry (chain_carry)
);

// File: tb/test_r1k_adder.sv
module test_r1k_adder;

    localparam int ND = 4;
    localparam int DW = 10;
    localparam int W  = ND * DW;

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  op_a;
    logic [W-1:0]  op_b;
    logic          carry_in;
    logic [W-1:0]  sum_out;
    logic          carry_out;

    int n_total;
    int n_fail;
    bit finished;

    r1k_adder #(.N_DIGITS(ND)) i_r1k_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // 50 MHz clock
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Integer reference: comparison against 1000, digit by digit.
    function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
        logic [W-1:0] r;
        int cy;
        cy = int'(c);
        r  = '0;
        for (int i = 0; i < ND; i++) begin
            int k;
            k = int'(a[i*DW +: DW]) + int'(b[i*DW +: DW]) + cy;
            if (k >= 1000) begin
                k  = k - 1000;
                cy = 1;
            end else begin
                cy = 0;
            end
            r[i*DW +: DW] = 10'(k);
        end
        return {cy[0], r};
    endfunction

    function automatic logic [DW-1:0] rand_digit();
        int sel;
        sel = int'($urandom % 8);
        if (sel == 0) return 10'd999;
        if (sel == 1) return 10'd0;
        return 10'($urandom % 1000);
    endfunction

    function automatic logic [W-1:0] rep_digit(int v);
        logic [W-1:0] r;
        for (int i = 0; i < ND; i++) r[i*DW +: DW] = 10'(v);
        return r;
    endfunction

    task automatic check(string tag, logic [W:0] exp_v);
        n_total++;
        if ({carry_out, sum_out} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual carry=%0b sum=%h expected carry=%0b sum=%h",
                     tag, carry_out, sum_out, exp_v[W], exp_v[W-1:0]);
        end
    endtask

    task automatic check_range(string tag);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < ND; i++) if (sum_out[i*DW +: DW] > 10'd999) ok = 1'b0;
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual sum=%h has a digit above 999, expected all <= 999",
                     tag, sum_out);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
    task automatic apply(string tag, logic [W-1:0] a, logic [W-1:0] b, logic c);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = c;
        @(negedge clk);
        check(tag, ref_add(a, b, c));
    endtask

    initial begin
        logic [W-1:0] a, b;
        logic [W:0]   prev;
        n_total  = 0;
        n_fail   = 0;
        finished = 1'b0;
        void'($urandom(32'd20231));

        rst_n    = 1'b0;
        op_a     = rep_digit(777);
        op_b     = rep_digit(555);
        carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset clears outputs", '0);
        rst_n = 1'b1;

        apply("R3 zero plus zero", '0, '0, 1'b0);

        a = '0; a[DW-1:0] = 10'd999;
        apply("R4 999+0+1 in digit 0", a, '0, 1'b1);

        apply("R4 R6 999+999+1 everywhere", rep_digit(999), rep_digit(999), 1'b1);

        apply("R5 R6 carry ripples through all 999s", rep_digit(999), '0, 1'b1);
        apply("R5 no carry_in keeps 999s", rep_digit(999), '0, 1'b0);

        a = rep_digit(500); b = rep_digit(499);
        apply("R5 pairs summing to 999 pass carry", a, b, 1'b1);

        a = '0; b = '0;
        a[(ND-1)*DW +: DW] = 10'd500; b[(ND-1)*DW +: DW] = 10'd500;
        apply("R6 overflow only in top digit", a, b, 1'b0);

        a = '0; b = '0; a[DW +: DW] = 10'd600; b[DW +: DW] = 10'd400;
        apply("R4 exact 1000 boundary", a, b, 1'b0);
        b[DW +: DW] = 10'd399;
        apply("R3 999 just below boundary", a, b, 1'b0);

        apply("R2 mixed digits", rep_digit(123), rep_digit(877), 1'b0);

        // R7 latency: new operands do not show before the next rising edge.
        prev = ref_add(rep_digit(123), rep_digit(877), 1'b0);
        @(negedge clk);
        op_a = rep_digit(321); op_b = rep_digit(456); carry_in = 1'b1;
        #3;
        check("R7 output not yet updated", prev);
        @(negedge clk);
        check("R7 output after one edge", ref_add(rep_digit(321), rep_digit(456), 1'b1));
        repeat (3) @(negedge clk);
        check("R7 output held with steady inputs", ref_add(rep_digit(321), rep_digit(456), 1'b1));

        for (int n = 0; n < 300; n++) begin
            logic c;
            for (int i = 0; i < ND; i++) begin
                a[i*DW +: DW] = rand_digit();
                b[i*DW +: DW] = rand_digit();
            end
            c = 1'($urandom % 2);
            apply("R2 random operands", a, b, c);
            check_range("R8 random output digits in range");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule